// File: doc/BRIEF.md
# Watchdog countdown timer with keyed restart

This block is a watchdog timer with 16-bit registers on a simple register bus. Once software turns it on, it counts down in half-second steps, taken from a slow `tick` input pulse, from a programmed period. If the count runs out, the block can raise a reset request to the chip's reset logic. Software keeps the system alive by writing a two-word key to the service register, which restarts the countdown from the full period. A single stray write cannot restart it.

A warning interrupt can fire a programmable number of ticks before expiry, so software has time to react. Software can also ask for a reset directly. The block records whether the most recent reset request came from software or from expiry. Three pause controls stop the countdown while the chip is in low-power, debug or wait mode. The mode itself is signalled on input pins.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n`, the registers read as follows: control 0x0010 (offset 0x0), reset status 0x0000 (offset 0x4), interrupt control 0x0000 (offset 0x6). Both `rst_req` and `irq` are low. The service register (0x2) and any other offset read 0.
- R2: Control bits 15:8 hold the timeout value T. Bit 2 enables the timer, and setting it loads the count with T+1. While the timer is enabled and not paused, each `tick` pulse takes one off the count. The tick that takes the count to zero is the expiry. If control bit 3 is 1, expiry raises `rst_req`. The count reloads with T+1 at expiry.
- R3: The enable bit is sticky. Writing 0 to control bit 2 after it is set leaves it reading 1, and the countdown carries on.
- R4: Writing 0x5555 to the service register arms the key. When the next service-register write is 0xAAAA, the count reloads with T+1. A service write of 0xAAAA with no key armed does nothing. Any other service write after 0x5555 disarms the key, except another 0x5555, which stays armed. Writes to other registers leave the key as it is.
- R5: When control bit 3 is 0, expiry does not raise `rst_req` and leaves the reset status alone. The count still reloads with T+1.
- R6: Writing control with bit 4 = 0 raises `rst_req`. Bit 4 is not stored and always reads 1.
- R7: `rst_req` goes high in the cycle after the triggering write or tick. It stays high for exactly RST_HOLD clock cycles (default 4).
- R8: In reset status, bit 0 means the last request came from software and bit 1 means it came from expiry. Each new request overwrites both bits. The bits stay set after `rst_req` falls and are cleared only by `rst_n`. Bus writes to this register have no effect.
- R9: Control bit 0 pauses counting while `lowpwr_mode` is high. Bit 1 pauses it while `debug_mode` is high. Bit 7 pauses it while `wait_mode` is high. A mode input whose pause bit is 0 has no effect.
- R10: Interrupt control bits 7:0 hold the warning level W. The flag in bit 14 sets on the tick that leaves W ticks to expiry, which is tick T+1-W after a load, when 1 <= W <= T. With W = 0 or W > T it never sets. `irq` is the flag ANDed with bit 15.
- R11: Writing 1 to interrupt control bit 14 clears the flag. Writing 0 there leaves it set.
- R12: While the enable bit is 0, ticks change nothing: `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high during `bus_sel` |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick | input | 1 | One-cycle half-second time base pulse |
| lowpwr_mode | input | 1 | Chip is in low-power mode |
| debug_mode | input | 1 | Chip is in debug mode |
| wait_mode | input | 1 | Chip is in wait mode |
| irq | output | 1 | Pre-timeout warning interrupt |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench sweeps every timeout from 0 to 4 against every warning level from 0 to 3. An off-by-one in the reload value or in the warning compare shows up there as an expiry or interrupt one tick early or late, or as a spurious warning at W = 0 or W > T. It also drives the broken key sequences: a lone 0xAAAA, a foreign word between the keys, a repeated 0x5555, and a write to another register between the keys. A decoder that ignores the ordering would restart the count and push expiry out by two ticks. Further tests count the exact width of the reset pulse and confirm that a clear-enable write leaves the watchdog running. They also check that a mode input alone does not pause counting, and that a status write or a write of 0 to the interrupt flag changes nothing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int TO_W  = 8;
  localparam int CNT_W = TO_W + 1;

  localparam logic [AW-1:0] OFF_CTL  = 4'h0;
  localparam logic [AW-1:0] OFF_SVC  = 4'h2;
  localparam logic [AW-1:0] OFF_STAT = 4'h4;
  localparam logic [AW-1:0] OFF_ICTL = 4'h6;

  localparam int CB_LPW  = 0;
  localparam int CB_DBG  = 1;
  localparam int CB_EN   = 2;
  localparam int CB_TRST = 3;
  localparam int CB_SRST = 4;
  localparam int CB_WAIT = 7;
  localparam int CB_TO   = 8;
  localparam int IB_FLAG = 14;
  localparam int IB_EN   = 15;

  localparam logic [DW-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DW-1:0] KEY_FIRE = 16'hAAAA;

  // full period in ticks for a timeout field value
  function automatic logic [CNT_W-1:0] period_of(input logic [TO_W-1:0] to);
    return {1'b0, to} + CNT_W'(1);
  endfunction

  // true when one more tick leaves exactly lvl ticks before expiry
  function automatic logic warn_hit(input logic [CNT_W-1:0] rem,
                                    input logic [TO_W-1:0]  lvl);
    return (lvl != '0) && ((rem - CNT_W'(1)) == {1'b0, lvl});
  endfunction
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int              W      = 16,
  parameter logic [W-1:0]    K_ARM  = '0,
  parameter logic [W-1:0]    K_FIRE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] data,
  output logic         reload
);
  logic armed_q;

  assign reload = wr && armed_q && (data == K_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (wr) armed_q <= (data == K_ARM);
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CW = 9,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] period,
  input  logic [WW-1:0] warn_lvl,
  output logic [CW-1:0] remain,
  output logic          expire,
  output logic          warn
);
  logic step;
  assign step   = run && !load;
  assign expire = step && (remain == CW'(1));
  assign warn   = step && wdog_pkg::warn_hit(remain, warn_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain <= '0;
    else if (load)   remain <= period;
    else if (expire) remain <= period;
    else if (step)   remain <= remain - CW'(1);
  end
endmodule

// File: rtl/wdog_pulse_hold.sv
module wdog_pulse_hold #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (trig)   cnt_q <= CW'(HOLD);
    else if (active) cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int RST_HOLD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        tick,
  input  logic        lowpwr_mode,
  input  logic        debug_mode,
  input  logic        wait_mode,
  output logic        irq,
  output logic        rst_req
);
  import wdog_pkg::*;

  // control and interrupt-control state
  logic [TO_W-1:0]  to_q, wlvl_q, new_to;
  logic             en_q, trst_q, lp_q, dbg_q, wt_q;
  logic             ien_q, iflag_q;
  logic [1:0]       stat_q;
  logic [CNT_W-1:0] remain;

  // named internal events
  logic wr_ctl, wr_svc, wr_ictl;
  logic svc_reload, enable_load, load, paused, run;
  logic expire, warn, soft_trig, tout_trig;

  assign wr_ctl  = bus_sel && bus_we && (bus_addr == OFF_CTL);
  assign wr_svc  = bus_sel && bus_we && (bus_addr == OFF_SVC);
  assign wr_ictl = bus_sel && bus_we && (bus_addr == OFF_ICTL);

  assign new_to      = wr_ctl ? bus_wdata[CB_TO +: TO_W] : to_q;
  assign enable_load = wr_ctl && bus_wdata[CB_EN] && !en_q;
  assign load        = enable_load || (svc_reload && en_q);
  assign paused      = (lp_q && lowpwr_mode) || (dbg_q && debug_mode) || (wt_q && wait_mode);
  assign run         = en_q && tick && !paused;
  assign soft_trig   = wr_ctl && !bus_wdata[CB_SRST];
  assign tout_trig   = expire && trst_q;

  wdog_key_seq #(.W(DW), .K_ARM(KEY_ARM), .K_FIRE(KEY_FIRE)) u_key (
    .clk(clk), .rst_n(rst_n), .wr(wr_svc), .data(bus_wdata), .reload(svc_reload)
  );

  wdog_countdown #(.CW(CNT_W), .WW(TO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .period(period_of(new_to)), .warn_lvl(wlvl_q),
    .remain(remain), .expire(expire), .warn(warn)
  );

  wdog_pulse_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .trig(soft_trig || tout_trig), .active(rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= '0; en_q <= 1'b0; trst_q <= 1'b0;
      lp_q <= 1'b0; dbg_q <= 1'b0; wt_q <= 1'b0;
    end else if (wr_ctl) begin
      to_q   <= bus_wdata[CB_TO +: TO_W];
      en_q   <= en_q || bus_wdata[CB_EN];
      trst_q <= bus_wdata[CB_TRST];
      lp_q   <= bus_wdata[CB_LPW];
      dbg_q  <= bus_wdata[CB_DBG];
      wt_q   <= bus_wdata[CB_WAIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlvl_q <= '0; ien_q <= 1'b0; iflag_q <= 1'b0;
    end else begin
      if (wr_ictl) begin
        wlvl_q <= bus_wdata[TO_W-1:0];
        ien_q  <= bus_wdata[IB_EN];
      end
      if (warn)                            iflag_q <= 1'b1;
      else if (wr_ictl && bus_wdata[IB_FLAG]) iflag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stat_q <= 2'b00;
    else if (soft_trig || tout_trig) stat_q <= {tout_trig, soft_trig};
  end

  assign irq = iflag_q && ien_q;

  always_comb begin
    unique case (bus_addr)
      OFF_CTL:  bus_rdata = {to_q, wt_q, 2'b00, 1'b1, trst_q, en_q, dbg_q, lp_q};
      OFF_STAT: bus_rdata = {14'd0, stat_q};
      OFF_ICTL: bus_rdata = {ien_q, iflag_q, 6'd0, wlvl_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en_q,
  input logic [wdog_pkg::CNT_W-1:0] remain,
  input logic [wdog_pkg::TO_W-1:0]  to_q,
  input logic                      load,
  input logic                      svc_reload,
  input logic                      paused,
  input logic                      rst_req,
  input logic                      irq,
  input logic                      ien_q,
  input logic [1:0]                stat_q
);
  // R3: enable never drops once set
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  // R2: an enabled timer never sits at a zero count
  a_r2_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (remain != '0));

  // R4: a completed key sequence restores the full period
  a_r4_key_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_reload && en_q) |=> (remain == wdog_pkg::period_of(to_q)));

  // R9: a paused timer holds its count
  a_r9_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && paused && !load) |=> $stable(remain));

  // R7: the reset request lasts more than one cycle
  a_r7_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |=> rst_req);

  // R8: every reset request leaves a recorded cause
  a_r8_cause_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (stat_q != 2'b00));

  // R10: interrupt only when enabled
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_q);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .remain(remain), .to_q(to_q),
  .load(load), .svc_reload(svc_reload), .paused(paused),
  .rst_req(rst_req), .irq(irq), .ien_q(ien_q), .stat_q(stat_q)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, bus_sel = 1'b0, bus_we = 1'b0, tick = 1'b0;
  logic        lowpwr_mode = 1'b0, debug_mode = 1'b0, wait_mode = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        irq, rst_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wdog_timer dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lowpwr_mode = 0; debug_mode = 0; wait_mode = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick = 1;
    @(posedge clk);
    #1 tick = 0;
  endtask

  // ticks up to n times; returns tick index of first rst_req / irq (0 = none)
  task automatic run_ticks(int n, output int first_rst, output int first_irq);
    first_rst = 0; first_irq = 0;
    for (int k = 1; k <= n; k++) begin
      tick1();
      @(negedge clk);
      if (rst_req && first_rst == 0) first_rst = k;
      if (irq && first_irq == 0) first_irq = k;
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    int fr, fi, hi;

    // R1 reset state
    do_reset();
    rd(4'h0, d); check("R1 ctl", d, 16'h0010);
    rd(4'h4, d); check("R1 status", d, 16'h0000);
    rd(4'h6, d); check("R1 ictl", d, 16'h0000);
    rd(4'h2, d); check("R1 svc", d, 16'h0000);
    check("R1 rst_req", rst_req, 0);
    check("R1 irq", irq, 0);

    // R2 / R10 sweep of timeout and warning level
    for (int t = 0; t <= 4; t++) begin
      for (int w = 0; w <= 3; w++) begin
        do_reset();
        wr(4'h6, 16'h8000 | 16'(w));
        wr(4'h0, (16'(t) << 8) | 16'h001C);
        run_ticks(t + 3, fr, fi);
        check($sformatf("R2 expiry T=%0d W=%0d", t, w), fr, t + 1);
        check($sformatf("R10 warn T=%0d W=%0d", t, w), fi,
              (w != 0 && w <= t) ? (t + 1 - w) : 0);
        settle();
        rd(4'h4, d); check($sformatf("R8 tout status T=%0d", t), d, 16'h0002);
      end
    end

    // R12 disabled timer ignores ticks
    do_reset();
    wr(4'h0, 16'h0018);
    run_ticks(5, fr, fi);
    check("R12 no expiry when disabled", fr, 0);
    rd(4'h4, d); check("R12 status untouched", d, 16'h0000);

    // R5 timeout without reset output, then restart
    do_reset();
    wr(4'h0, 16'h0214);
    run_ticks(3, fr, fi);
    check("R5 no rst_req", fr, 0);
    rd(4'h4, d); check("R5 status unchanged", d, 16'h0000);
    wr(4'h0, 16'h021C);
    run_ticks(4, fr, fi);
    check("R5 count restarted at full period", fr, 3);

    // R3 enable is sticky
    do_reset();
    wr(4'h0, 16'h0114);
    wr(4'h0, 16'h0118);
    rd(4'h0, d); check("R3 enable reads 1", d, 16'h011C);
    run_ticks(3, fr, fi);
    check("R3 keeps counting", fr, 2);

    // R4 key sequences, T=3: good reload gives expiry 4 ticks after it
    do_reset(); wr(4'h0, 16'h031C); run_ticks(2, fr, fi);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    run_ticks(5, fr, fi); check("R4 proper key reloads", fr, 4);

    do_reset(); wr(4'h0, 16'h031C); run_ticks(2, fr, fi);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    run_ticks(5, fr, fi); check("R4 foreign word cancels", fr, 2);

    do_reset(); wr(4'h0, 16'h031C); run_ticks(2, fr, fi);
    wr(4'h2, 16'hAAAA);
    run_ticks(5, fr, fi); check("R4 lone second key ignored", fr, 2);

    do_reset(); wr(4'h0, 16'h031C); run_ticks(2, fr, fi);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    run_ticks(5, fr, fi); check("R4 repeated first key stays armed", fr, 4);

    do_reset(); wr(4'h0, 16'h031C); run_ticks(2, fr, fi);
    wr(4'h2, 16'h5555); wr(4'h0, 16'h031C); wr(4'h2, 16'hAAAA);
    run_ticks(5, fr, fi); check("R4 other register write keeps key", fr, 4);

    // R6 / R7 software reset request and pulse width
    do_reset();
    wr(4'h0, 16'h0000);
    hi = 0;
    @(negedge clk);
    check("R7 asserted cycle after write", rst_req, 1);
    if (rst_req) hi++;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (rst_req) hi++;
    end
    check("R7 pulse width", hi, 4);
    rd(4'h4, d); check("R8 soft status", d, 16'h0001);
    rd(4'h0, d); check("R6 bit4 reads 1", d, 16'h0010);

    // R8 overwrite by newer cause, write ignored
    do_reset();
    wr(4'h0, 16'h001C);
    run_ticks(1, fr, fi);
    check("R8 T=0 expiry", fr, 1);
    settle();
    wr(4'h0, 16'h000C);
    settle();
    rd(4'h4, d); check("R8 newer cause overwrites", d, 16'h0001);
    wr(4'h4, 16'hFFFF);
    rd(4'h4, d); check("R8 status write ignored", d, 16'h0001);

    // R9 pause controls
    for (int s = 0; s < 3; s++) begin
      int b;
      b = (s == 0) ? 0 : (s == 1) ? 1 : 7;
      do_reset();
      wr(4'h0, 16'h011C | (16'h1 << b));
      lowpwr_mode = (s == 0); debug_mode = (s == 1); wait_mode = (s == 2);
      run_ticks(3, fr, fi);
      check($sformatf("R9 paused by bit %0d", b), fr, 0);
      lowpwr_mode = 0; debug_mode = 0; wait_mode = 0;
      run_ticks(3, fr, fi);
      check($sformatf("R9 resumes after bit %0d", b), fr, 2);
    end
    do_reset();
    wr(4'h0, 16'h011C);
    lowpwr_mode = 1; debug_mode = 1; wait_mode = 1;
    run_ticks(3, fr, fi);
    check("R9 mode inputs alone do not pause", fr, 2);

    // R10 / R11 flag, enable gate and clearing
    do_reset();
    wr(4'h6, 16'h0001);
    wr(4'h0, 16'h021C);
    run_ticks(2, fr, fi);
    check("R10 irq masked", irq, 0);
    rd(4'h6, d); check("R10 flag set", d, 16'h4001);
    wr(4'h6, 16'h0001);
    rd(4'h6, d); check("R11 write 0 keeps flag", d, 16'h4001);
    wr(4'h6, 16'h8001);
    @(negedge clk); check("R10 irq when enabled", irq, 1);
    wr(4'h6, 16'hC001);
    @(negedge clk); check("R11 irq after clear", irq, 0);
    rd(4'h6, d); check("R11 flag cleared", d, 16'h8001);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule